// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received Ethernet frames into system memory. Software lays out a ring of descriptors in memory. Each descriptor is two 32-bit words: a buffer word and then a status word. The engine holds a pointer into that ring. When a frame begins, it reads the buffer word under the pointer to find out whether hardware owns the buffer. If it does, the engine streams the frame bytes into that buffer as 32-bit writes. It then records the frame length and boundaries in the status word and finally hands the buffer back to software by setting the ownership flag.

In the buffer word, bit 0 is the ownership flag. Software clears it to lend the buffer to hardware, and hardware sets it when the buffer is full. Bit 1 marks the last descriptor of the ring. Bits 31:2 give the word-aligned buffer start. A frame that meets a buffer still held by software is consumed and thrown away, and a one-cycle buffer-unavailable pulse is raised. An optional mode strips the trailing four-byte frame check sequence before storage.

The engine reaches memory through a simple request/grant port. Read data returns one cycle after the read is granted. Bytes arrive on a valid/ready stream with an end-of-frame marker.

Top module: `rxr_rx_ring`

## Requirements
- R1: After reset the engine makes no memory request, does not accept bytes (`rx_ready_o` low), holds `bna_o` low, and its ring pointer and queue base are address 0.
- R2: When a frame starts, the engine reads the buffer word at the ring pointer. If bit 0 of that word is clear, the frame's first byte is stored at the address formed by bits 31:2 of the word with bits 1:0 zero.
- R3: If bit 0 of the fetched buffer word is set, the engine accepts and discards every byte of the frame, makes no memory write, and pulses `bna_o` high for exactly one cycle. The ring pointer does not move, so the next frame fetches the same descriptor.
- R4: Stored byte k of a frame goes to buffer address + k. Byte lane j of `mem_wdata_o` carries bits 8j+7:8j and is addressed by `mem_be_o[j]`. Each frame uses one write per word touched, and only the lanes that hold frame bytes are enabled.
- R5: After the last data write, the engine writes the status word at descriptor + 4. This word has bit 15 (end of frame) = 1, bit 14 (start of frame) = 1, the stored length in bits 13:0, and all other bits 0.
- R6: After the status write, the engine rewrites the buffer word at the descriptor with bit 0 set and bits 31:1 unchanged. This is the frame's final write.
- R7: After the write-back the pointer moves to descriptor + 8, or back to the queue base when bit 1 of the buffer word was set.
- R8: A pulse on `qbase_wr_i` loads the queue base and the ring pointer with `qbase_i`, with bits 2:0 forced to 0. Descriptor fetches are always 8-byte aligned.
- R9: With `strip_fcs_i` high, the final four bytes of a frame are neither written nor counted. A frame of four bytes or fewer stores nothing and reports length 0.
- R10: At most `BUF_BYTES` (default 1536) bytes are stored per frame. Later bytes are accepted but discarded, and the length reads `BUF_BYTES`.
- R11: A memory request that is not granted stays asserted, with the same address, direction and write data, until it is granted.
- R12: Every memory write has at least one byte enable set and happens while `rx_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| qbase_wr_i | input | 1 | Load queue base and ring pointer |
| qbase_i | input | 32 | New queue base address |
| strip_fcs_i | input | 1 | Drop the last four bytes of each frame |
| rx_valid_i | input | 1 | Frame byte valid |
| rx_data_i | input | 8 | Frame byte |
| rx_last_i | input | 1 | Byte is the last of its frame |
| rx_ready_o | output | 1 | Byte accepted on this edge when valid |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Write byte enables |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rdata_i | input | 32 | Read data, valid one cycle after a granted read |
| bna_o | output | 1 | One-cycle pulse: frame dropped, buffer owned by software |

## Verification
A stale ring pointer shows up on the very next frame: the read address of the descriptor fetch is compared with the position a software model expects. A wrong wrap is caught the moment the ring rolls over. Errors in the byte packer or the trailing-byte delay line show up within one frame, either as mismatched buffer contents, a disturbed guard byte just past the stored length, or a wrong length field. A broken ownership handoff shows up as a write count or write order that differs from data words followed by status and then buffer word, or as an unexpected write or missing `bna_o` pulse on a frame that should have been dropped.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int DW          = 32;
  localparam int USED_BIT    = 0;
  localparam int WRAP_BIT    = 1;
  localparam int EOF_BIT     = 15;
  localparam int SOF_BIT     = 14;
  localparam int LEN_FIELD_W = 14;
  localparam int DESC_STRIDE = 8;
  localparam int FCS_BYTES   = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_WAIT,
    S_DATA,
    S_WB_STAT,
    S_WB_ADDR,
    S_DROP
  } rx_state_e;
endpackage

// File: rtl/rxr_fcs_strip.sv
// Delays the byte stream by TAIL bytes when enabled; bytes still held at frame end are discarded.
module rxr_fcs_strip #(
  parameter int TAIL = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       fire_i,
  input  logic [7:0] data_i,
  input  logic       last_i,
  output logic       valid_o,
  output logic [7:0] data_o,
  output logic       end_o
);
  localparam int FW = $clog2(TAIL + 1);

  logic [7:0]    pipe_q [TAIL];
  logic [FW-1:0] fill_q;
  logic          full;

  assign full  = (fill_q == FW'(TAIL));
  assign end_o = fire_i && last_i;

  always_comb begin
    if (en_i) begin
      valid_o = fire_i && full;
      data_o  = pipe_q[0];
    end else begin
      valid_o = fire_i;
      data_o  = data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      for (int i = 0; i < TAIL; i++) pipe_q[i] <= '0;
    end else if (en_i && fire_i) begin
      if (last_i) begin
        fill_q <= '0;
      end else if (full) begin
        for (int i = 0; i < TAIL - 1; i++) pipe_q[i] <= pipe_q[i+1];
        pipe_q[TAIL-1] <= data_i;
      end else begin
        for (int i = 0; i < TAIL; i++)
          if (FW'(i) == fill_q) pipe_q[i] <= data_i;
        fill_q <= fill_q + FW'(1);
      end
    end
  end
endmodule

// File: rtl/rxr_word_pack.sv
// Gathers bytes into little-endian words, caps the stored count, flushes the tail word at frame end.
module rxr_word_pack #(
  parameter int BUF_BYTES = 1536,
  parameter int LEN_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  input  logic             end_i,
  input  logic             gnt_i,
  output logic             pend_o,
  output logic [31:0]      data_o,
  output logic [3:0]       be_o,
  output logic [LEN_W-1:0] off_o,
  output logic [LEN_W-1:0] len_o,
  output logic             done_o
);
  localparam logic [LEN_W-1:0] CAP = LEN_W'(BUF_BYTES);

  logic [31:0]      wbuf_q, wbuf_n;
  logic [3:0]       be_q, be_n;
  logic [1:0]       lane_q;
  logic [LEN_W-1:0] cnt_q, off_q;
  logic             pend_q, fin_q;
  logic             take, full, pend_set;

  always_comb begin
    take   = byte_valid_i && (cnt_q < CAP);
    wbuf_n = wbuf_q;
    be_n   = be_q;
    if (take) begin
      wbuf_n[{lane_q, 3'b000} +: 8] = byte_i;
      be_n[lane_q]                  = 1'b1;
    end
    full     = take && (lane_q == 2'd3);
    pend_set = full || (end_i && (be_n != 4'b0));
    done_o   = (end_i && (be_n == 4'b0)) || (pend_q && gnt_i && fin_q);
  end

  assign pend_o = pend_q;
  assign data_o = wbuf_q;
  assign be_o   = be_q;
  assign off_o  = off_q;
  assign len_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbuf_q <= '0;
      be_q   <= '0;
      lane_q <= '0;
      cnt_q  <= '0;
      off_q  <= '0;
      pend_q <= 1'b0;
      fin_q  <= 1'b0;
    end else if (clear_i) begin
      wbuf_q <= '0;
      be_q   <= '0;
      lane_q <= '0;
      cnt_q  <= '0;
      off_q  <= '0;
      pend_q <= 1'b0;
      fin_q  <= 1'b0;
    end else if (pend_q) begin
      if (gnt_i) begin
        pend_q <= 1'b0;
        fin_q  <= 1'b0;
        be_q   <= '0;
        off_q  <= off_q + LEN_W'(4);
      end
    end else begin
      wbuf_q <= wbuf_n;
      be_q   <= be_n;
      pend_q <= pend_set;
      fin_q  <= end_i && (be_n != 4'b0);
      if (take) begin
        lane_q <= lane_q + 2'd1;
        cnt_q  <= cnt_q + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        base_wr_i,
  input  logic [31:0] base_i,
  input  logic        adv_i,
  input  logic        wrap_i,
  output logic [31:0] ptr_o
);
  import rxr_pkg::*;

  logic [31:0] base_q, ptr_q;

  assign ptr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else if (base_wr_i) begin
      base_q <= base_i & ~32'(DESC_STRIDE - 1);
      ptr_q  <= base_i & ~32'(DESC_STRIDE - 1);
    end else if (adv_i) begin
      ptr_q <= wrap_i ? base_q : ptr_q + 32'(DESC_STRIDE);
    end
  end
endmodule

// File: rtl/rxr_rx_ring.sv
module rxr_rx_ring #(
  parameter int BUF_BYTES = 1536
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        qbase_wr_i,
  input  logic [31:0] qbase_i,
  input  logic        strip_fcs_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_last_i,
  output logic        rx_ready_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  output logic [3:0]  mem_be_o,
  input  logic        mem_gnt_i,
  input  logic [31:0] mem_rdata_i,
  output logic        bna_o
);
  import rxr_pkg::*;

  localparam int LEN_W = $clog2(BUF_BYTES + 1);

  rx_state_e        state_q, state_n;
  logic [31:0]      ptr, buf_q;
  logic             wrap_q, bna_q;
  logic             fire, adv;
  logic             st_valid, st_end;
  logic [7:0]       st_data;
  logic             pk_pend, pk_done;
  logic [31:0]      pk_data;
  logic [3:0]       pk_be;
  logic [LEN_W-1:0] pk_off, pk_len;
  logic [LEN_FIELD_W-1:0] len_fld;
  logic [31:0]      stat_word;

  assign rx_ready_o = ((state_q == S_DATA) && !pk_pend) || (state_q == S_DROP);
  assign fire       = rx_valid_i && rx_ready_o;
  assign adv        = (state_q == S_WB_ADDR) && mem_gnt_i;
  assign bna_o      = bna_q;

  rxr_ring_ptr u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .base_wr_i (qbase_wr_i),
    .base_i    (qbase_i),
    .adv_i     (adv),
    .wrap_i    (wrap_q),
    .ptr_o     (ptr)
  );

  rxr_fcs_strip #(.TAIL(FCS_BYTES)) u_strip (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (strip_fcs_i),
    .fire_i  (fire && (state_q == S_DATA)),
    .data_i  (rx_data_i),
    .last_i  (rx_last_i),
    .valid_o (st_valid),
    .data_o  (st_data),
    .end_o   (st_end)
  );

  rxr_word_pack #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_pack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (state_q == S_WAIT),
    .byte_valid_i (st_valid),
    .byte_i       (st_data),
    .end_i        (st_end),
    .gnt_i        (mem_gnt_i && (state_q == S_DATA)),
    .pend_o       (pk_pend),
    .data_o       (pk_data),
    .be_o         (pk_be),
    .off_o        (pk_off),
    .len_o        (pk_len),
    .done_o       (pk_done)
  );

  always_comb begin
    len_fld            = LEN_FIELD_W'(pk_len);
    stat_word          = '0;
    stat_word[EOF_BIT] = 1'b1;
    stat_word[SOF_BIT] = 1'b1;
    stat_word[LEN_FIELD_W-1:0] = len_fld;
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr;
    mem_wdata_o = '0;
    mem_be_o    = '0;
    unique case (state_q)
      S_FETCH: mem_req_o = 1'b1;
      S_DATA: begin
        mem_req_o   = pk_pend;
        mem_we_o    = pk_pend;
        mem_addr_o  = buf_q + 32'(pk_off);
        mem_wdata_o = pk_data;
        mem_be_o    = pk_be;
      end
      S_WB_STAT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ptr + 32'd4;
        mem_wdata_o = stat_word;
        mem_be_o    = 4'hf;
      end
      S_WB_ADDR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = {buf_q[31:2], wrap_q, 1'b1};
        mem_be_o    = 4'hf;
      end
      default: ;
    endcase
  end

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      S_IDLE:    if (rx_valid_i) state_n = S_FETCH;
      S_FETCH:   if (mem_gnt_i) state_n = S_WAIT;
      S_WAIT:    state_n = mem_rdata_i[USED_BIT] ? S_DROP : S_DATA;
      S_DATA:    if (pk_done) state_n = S_WB_STAT;
      S_WB_STAT: if (mem_gnt_i) state_n = S_WB_ADDR;
      S_WB_ADDR: if (mem_gnt_i) state_n = S_IDLE;
      S_DROP:    if (fire && rx_last_i) state_n = S_IDLE;
      default:   state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      buf_q   <= '0;
      wrap_q  <= 1'b0;
      bna_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      bna_q   <= (state_q == S_WAIT) && mem_rdata_i[USED_BIT];
      if (state_q == S_WAIT && !mem_rdata_i[USED_BIT]) begin
        buf_q  <= {mem_rdata_i[31:2], 2'b00};
        wrap_q <= mem_rdata_i[WRAP_BIT];
      end
    end
  end
endmodule

// File: rtl/rxr_rx_ring_chk.sv
module rxr_rx_ring_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        qbase_wr_i,
  input logic        rx_ready_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic [3:0]  mem_be_o,
  input logic        mem_gnt_i,
  input logic        bna_o
);
  assert_write_stalls_input_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !rx_ready_o);

  assert_write_has_lanes_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_be_o != 4'b0);

  assert_req_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i && !qbase_wr_i |=>
      mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_bna_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bna_o |=> !bna_o);

  assert_bna_no_access_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bna_o |-> !mem_req_o);

  assert_fetch_aligned_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> mem_addr_o[2:0] == 3'b000);
endmodule

bind rxr_rx_ring rxr_rx_ring_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .qbase_wr_i  (qbase_wr_i),
  .rx_ready_o  (rx_ready_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_be_o    (mem_be_o),
  .mem_gnt_i   (mem_gnt_i),
  .bna_o       (bna_o)
);

// File: tb/sim_rxr_rx_ring.sv
module sim_rxr_rx_ring;
  localparam int CLK_PERIOD = 10;
  localparam int BUF = 1536;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        qbase_wr = 1'b0;
  logic [31:0] qbase = '0;
  logic        strip = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_last = 1'b0;
  logic        rx_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_gnt = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        bna;

  rxr_rx_ring #(.BUF_BYTES(BUF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .qbase_wr_i(qbase_wr), .qbase_i(qbase),
    .strip_fcs_i(strip), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_last_i(rx_last), .rx_ready_o(rx_ready), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_be_o(mem_be), .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata),
    .bna_o(bna)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem [0:16383];
  logic [7:0]  fb  [0:2047];
  int checks = 0, errors = 0;
  int wr_cnt = 0, bna_cnt = 0, r11_bad = 0, r12_bad = 0;
  logic [31:0] last_wr = '0, prev_wr = '0, last_rd = 32'hffff_ffff;
  logic        stall_q = 1'b0;
  logic [31:0] stall_addr = '0;
  logic [31:0] exp_ptr = '0, exp_base = '0;
  string       fetch_tag = "R7";
  bit          done = 1'b0;

  // memory model: grant decided at negedge, read data one cycle after grant
  always @(negedge clk) mem_gnt <= ($urandom % 4) != 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (stall_q && (!mem_req || mem_addr != stall_addr)) r11_bad++;
      stall_q    = mem_req && !mem_gnt;
      stall_addr = mem_addr;
      if (bna) bna_cnt++;
      if (mem_req && mem_gnt) begin
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[15:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
          if (rx_ready || mem_be == 4'b0) r12_bad++;
          wr_cnt++;
          prev_wr = last_wr;
          last_wr = mem_addr;
        end else begin
          mem_rdata <= mem[mem_addr[15:2]];
          last_rd = mem_addr;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] get_byte(input logic [31:0] a);
    return mem[a[15:2]][{a[1:0], 3'b000} +: 8];
  endfunction

  task automatic send_frame(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = fb[i];
      rx_last  = (i == n - 1);
      while (!rx_ready) @(negedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_last  = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic do_frame(input int n, input bit s);
    logic [31:0] ptr, aw, bufa, st;
    int w0, b0, stored, bad;
    string rq;
    ptr = exp_ptr;
    aw  = mem[ptr[15:2]];
    w0  = wr_cnt;
    b0  = bna_cnt;
    bufa = {aw[31:2], 2'b00};
    for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
    if (!aw[0]) for (int k = 0; k < 400; k++) mem[bufa[15:2] + 14'(k)] = 32'hA5A5_A5A5;
    strip = s;
    send_frame(n);
    chk(last_rd == ptr, fetch_tag, "descriptor fetch address", last_rd, ptr);
    fetch_tag = "R7";
    if (aw[0]) begin
      chk(bna_cnt == b0 + 1, "R3", "one bna pulse on owned buffer", 32'(bna_cnt - b0), 1);
      chk(wr_cnt == w0, "R3", "no writes for dropped frame", 32'(wr_cnt - w0), 0);
    end else begin
      stored = s ? ((n > 4) ? n - 4 : 0) : n;
      if (stored > BUF) stored = BUF;
      if (stored > 0)
        chk(get_byte(bufa) == fb[0], "R2", "first byte at buffer start", get_byte(bufa), fb[0]);
      bad = 0;
      for (int i = 0; i < stored; i++) if (get_byte(bufa + 32'(i)) != fb[i]) bad++;
      chk(bad == 0, "R4", "buffer byte mismatches", 32'(bad), 0);
      rq = s ? "R9" : ((stored == BUF) ? "R10" : "R4");
      chk(get_byte(bufa + 32'(stored)) == 8'hA5, rq, "byte past stored length untouched",
          get_byte(bufa + 32'(stored)), 8'hA5);
      st = 32'h0000_C000 | 32'(stored);
      chk(mem[ptr[15:2] + 14'd1] == st, "R5", "status word", mem[ptr[15:2] + 14'd1], st);
      chk(mem[ptr[15:2]] == (aw | 32'd1), "R6", "buffer word handed back",
          mem[ptr[15:2]], aw | 32'd1);
      chk(wr_cnt - w0 == (stored + 3) / 4 + 2, "R4", "write count",
          32'(wr_cnt - w0), 32'((stored + 3) / 4 + 2));
      chk(prev_wr == ptr + 4 && last_wr == ptr, "R6", "status then buffer word last",
          last_wr, ptr);
      chk(bna_cnt == b0, "R3", "no bna on free buffer", 32'(bna_cnt - b0), 0);
      exp_ptr = aw[1] ? exp_base : ptr + 32'd8;
      mem[ptr[15:2]] = aw;
    end
  endtask

  task automatic set_base(input logic [31:0] v);
    @(negedge clk);
    qbase_wr = 1'b1;
    qbase    = v;
    @(negedge clk);
    qbase_wr = 1'b0;
    exp_base = v & ~32'h7;
    exp_ptr  = exp_base;
    fetch_tag = "R8";
  endtask

  task automatic make_ring(input logic [31:0] base, input int cnt, input logic [31:0] buf0);
    for (int i = 0; i < cnt; i++) begin
      mem[base[15:2] + 14'(2*i)]     = (buf0 + 32'(i * 32'h800)) | ((i == cnt - 1) ? 32'd2 : 32'd0);
      mem[base[15:2] + 14'(2*i + 1)] = 32'h0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < 16384; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!mem_req && !rx_ready && !bna, "R1", "outputs quiet in reset",
        {29'b0, mem_req, rx_ready, bna}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !rx_ready && !bna, "R1", "outputs quiet after reset",
        {29'b0, mem_req, rx_ready, bna}, 0);
    // R1: pointer starts at 0; descriptor there is owned by software
    mem[0] = 32'h0000_0801;
    fetch_tag = "R1";
    do_frame(6, 1'b0);
    chk(exp_ptr == 0, "R3", "pointer held after drop", exp_ptr, 0);

    set_base(32'h0000_0105);
    make_ring(32'h100, 4, 32'h1000);
    for (int f = 0; f < 10; f++) do_frame(1 + int'($urandom % 120), 1'($urandom % 2));

    do_frame(3, 1'b1);
    do_frame(4, 1'b1);
    do_frame(5, 1'b1);
    do_frame(1, 1'b0);
    do_frame(7, 1'b0);
    do_frame(BUF + 4, 1'b0);
    do_frame(BUF + 9, 1'b1);

    // R3: current buffer still owned by software, then returned
    mem[exp_ptr[15:2]] = mem[exp_ptr[15:2]] | 32'd1;
    do_frame(20, 1'b0);
    mem[exp_ptr[15:2]] = mem[exp_ptr[15:2]] & ~32'd1;
    fetch_tag = "R3";
    do_frame(21, 1'b0);

    set_base(32'h0000_0203);
    make_ring(32'h200, 2, 32'h5000);
    for (int f = 0; f < 4; f++) do_frame(9 + f * 13, 1'(f % 2));

    chk(r11_bad == 0, "R11", "ungranted request changed", 32'(r11_bad), 0);
    chk(r12_bad == 0, "R12", "write with ready high or no lanes", 32'(r12_bad), 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule